// File: doc/BRIEF.md
# Backup Register Mirror Sequencer

This block keeps eight fast-domain shadow registers and a matching set of always-on backup copies, held here as flip-flops. Software writes a shadow register through a write strobe carrying a register index and data. The write updates the shadow at once and marks that register stale. A sequencer then moves the stale registers into the backup copies one at a time.

Each move occupies a transfer window of a fixed number of slow-domain ticks. The tick arrives as a one-cycle pulse already in the fast clock domain. The index order is, from 0 upward: six persistent words (indices 0 to 5), the alarm word (6) and the seconds word (7). The lowest stale index always goes first, so the seconds word is committed last.

A 32-bit status word carries two masks. The stale mask sits in bits 23:16; for example, the seconds word is mask value 0x80. The new-data mask sits in bits 15:8 and is cleared by a status read. Software can poll the seconds stale bit to learn when a full refresh is done.

Top module: `bkm_mirror_seq`

## Requirements
- R1: After reset, status reads zero, and every shadow and backup word reads zero.
- R2: A write to index i loads that shadow word on the same clock edge and sets status bit 16+i. The backup word for index i is left unchanged until its copy commits.
- R3: Only one copy runs at a time. When the sequencer is idle it starts the lowest-numbered stale index. A full refresh therefore commits indices 0 to 7 in ascending order, and status bit 23 (the seconds word) clears last.
- R4: A copy commits on the XFER_TICKS-th tick counted after the cycle in which it started, and not before. On the commit edge, the backup word takes the shadow value, the stale bit i clears and the new-data bit 8+i sets.
- R5: A write to the index whose copy is in flight restarts that copy's tick count and keeps its stale bit set. The backup then receives the latest value, XFER_TICKS ticks after the restarting write.
- R6: A write to index 1 with data bit 31 set marks all eight indices stale, which forces a full refresh.
- R7: A status read pulse clears the new-data mask on the next edge. If a copy commits on that same edge, its new-data bit is still set.
- R8: Ticks that arrive while nothing is stale have no effect: the status word, including the unused bits 31:24 and 7:0, stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_idx | input | 3 | Index of the shadow word being written |
| wr_data | input | DW | Write data |
| slow_tick | input | 1 | One-cycle pulse per slow-domain tick |
| stat_rd | input | 1 | Status read pulse; clears the new-data mask |
| rd_idx | input | 3 | Index selecting the shadow and backup words shown on the outputs |
| status | output | 32 | Stale mask in bits 23:16, new-data mask in bits 15:8, all other bits zero |
| shadow_q | output | DW | Shadow word at rd_idx |
| backup_q | output | DW | Backup word at rd_idx |

## Verification
The assertions assume the following about the inputs:
- slow_tick is a clean single-cycle pulse.
- A write and a status read may land on any cycle, including a commit edge.
- No input is ever X after reset.

The bench keeps to these assumptions. Every tick is one cycle high followed by at least one cycle low. All inputs are driven on the falling edge. A copy is never counted until a separate idle cycle has let the sequencer start. The restart case puts its second write on a cycle with no tick, so the restart point is unambiguous.

// File: rtl/bkm_pkg.sv
package bkm_pkg;
  localparam int NREG      = 8;
  localparam int IDXW      = 3;
  localparam int STALE_LSB = 16;
  localparam int NEW_LSB   = 8;
  localparam int FORCE_IDX = 1;

  typedef logic [NREG-1:0] mask_t;

  // lowest set bit of a mask; zero when the mask is empty
  function automatic logic [IDXW-1:0] first_stale(mask_t m);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (m[i]) r = IDXW'(i);
    return r;
  endfunction

  function automatic logic [31:0] pack_status(mask_t stale, mask_t fresh);
    logic [31:0] s;
    s = '0;
    s[STALE_LSB +: NREG] = stale;
    s[NEW_LSB +: NREG]   = fresh;
    return s;
  endfunction
endpackage

// File: rtl/bkm_bank.sv
module bkm_bank
  import bkm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            cp_en,
  input  logic [IDXW-1:0] cp_idx,
  input  logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   shadow_q,
  output logic [DW-1:0]   backup_q
);
  logic [DW-1:0] shd [NREG];
  logic [DW-1:0] bku [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    wire wsel = wr_en && (wr_idx == IDXW'(g));
    wire csel = cp_en && (cp_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd[g] <= '0;
        bku[g] <= '0;
      end else begin
        if (wsel) shd[g] <= wr_data;
        if (csel) bku[g] <= shd[g];
      end
    end
  end

  assign shadow_q = shd[rd_idx];
  assign backup_q = bku[rd_idx];
endmodule

// File: rtl/bkm_timer.sv
module bkm_timer #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic restart,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = busy && tick && !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (restart)   cnt <= '0;
      else if (done) busy <= 1'b0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  // R4
  cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && restart) |=> (busy && cnt == '0));
endmodule

// File: rtl/bkm_mirror_seq.sv
module bkm_mirror_seq
  import bkm_pkg::*;
#(
  parameter int DW         = 32,
  parameter int XFER_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          slow_tick,
  input  logic          stat_rd,
  input  logic [2:0]    rd_idx,
  output logic [31:0]   status,
  output logic [DW-1:0] shadow_q,
  output logic [DW-1:0] backup_q
);
  localparam int FORCE_BIT = DW - 1;

  mask_t           stale_q, fresh_q;
  logic [IDXW-1:0] cur_idx;
  logic            busy, done, start, hit_cur, force_all;
  mask_t           commit_vec;

  assign start     = !busy && (|stale_q);
  assign hit_cur   = wr_en && busy && (wr_idx == cur_idx);
  assign force_all = wr_en && (wr_idx == IDXW'(FORCE_IDX)) && wr_data[FORCE_BIT];
  assign commit_vec = done ? (mask_t'(1) << cur_idx) : '0;

  bkm_timer #(.TICKS(XFER_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .restart(hit_cur),
    .tick(slow_tick), .busy(busy), .done(done)
  );

  bkm_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cp_en(done), .cp_idx(cur_idx), .rd_idx(rd_idx),
    .shadow_q(shadow_q), .backup_q(backup_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_idx <= '0;
    else if (start) cur_idx <= first_stale(stale_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_q <= '0;
    end else begin
      mask_t nxt;
      nxt = stale_q & ~commit_vec;
      if (wr_en) nxt[wr_idx] = 1'b1;
      if (force_all) nxt = '1;
      stale_q <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= '0;
    else fresh_q <= (stat_rd ? '0 : fresh_q) | commit_vec;
  end

  assign status = pack_status(stale_q, fresh_q);

  // R2
  wr_marks_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stale_q[$past(wr_idx)]);

  // R3
  single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_vec) && ((commit_vec & ~stale_q) == '0));

  // R4
  commit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> (!stale_q[$past(cur_idx)] && fresh_q[$past(cur_idx)]));

  // R5
  restart_keeps_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cur |=> (busy && stale_q[$past(cur_idx)]));

  // R6
  force_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_all |=> (stale_q == '1));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> (fresh_q == '0));

  // R8
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stale_q == '0 && !wr_en) |=> (stale_q == '0 && !busy));
endmodule

// File: tb/bkm_mirror_seq_test.sv
module bkm_mirror_seq_test;
  localparam int DW = 32;
  localparam int T  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic          slow_tick = 1'b0;
  logic          stat_rd = 1'b0;
  logic [2:0]    rd_idx = '0;
  logic [31:0]   status;
  logic [DW-1:0] shadow_q, backup_q;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  bkm_mirror_seq #(.DW(DW), .XFER_TICKS(T)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .slow_tick(slow_tick), .stat_rd(stat_rd),
    .rd_idx(rd_idx), .status(status), .shadow_q(shadow_q), .backup_q(backup_q)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] i, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic run_copy();
    @(negedge clk);
    ticks(T);
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  // stimulus table: index, data
  typedef struct packed { logic [2:0] idx; logic [31:0] dat; } vec_t;
  localparam vec_t VECS [6] = '{
    '{3'd7, 32'h1234_5678}, '{3'd0, 32'h0000_00A5}, '{3'd3, 32'hDEAD_0003},
    '{3'd6, 32'h0BAD_F00D}, '{3'd5, 32'h5555_AAAA}, '{3'd2, 32'h0000_0002}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 32'h0, "R1 status", status, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #1;
      chk(shadow_q == '0 && backup_q == '0, "R1 words", backup_q | shadow_q, 32'h0);
    end

    // R8 ticks while idle
    ticks(5);
    chk(status == 32'h0, "R8 idle ticks", status, 32'h0);

    // vector walk: R2 + R4 + R7
    foreach (VECS[v]) begin
      rd_idx = VECS[v].idx;
      wr(VECS[v].idx, VECS[v].dat);
      chk(shadow_q == VECS[v].dat, "R2 shadow", shadow_q, VECS[v].dat);
      chk(status[23:16] == (8'h1 << VECS[v].idx), "R2 stale", 32'(status[23:16]), 32'(8'h1 << VECS[v].idx));
      @(negedge clk);
      ticks(T - 1);
      chk(backup_q != VECS[v].dat, "R4 early", backup_q, VECS[v].dat);
      ticks(1);
      chk(backup_q == VECS[v].dat, "R4 backup", backup_q, VECS[v].dat);
      chk(status == {8'h0, 8'h0, 8'h1 << VECS[v].idx, 8'h0}, "R4 masks", status,
          {8'h0, 8'h0, 8'h1 << VECS[v].idx, 8'h0});
      rd_status();
      chk(status == 32'h0, "R7 read clears", status, 32'h0);
    end

    // R5 restart of in-flight copy
    rd_idx = 3'd4;
    wr(3'd4, 32'h0000_1111);
    @(negedge clk);
    ticks(2);
    wr(3'd4, 32'h0000_2222);
    chk(status[20] == 1'b1, "R5 stale kept", 32'(status[23:16]), 32'h10);
    ticks(T - 1);
    chk(backup_q == 32'h0, "R5 not early", backup_q, 32'h0);
    ticks(1);
    chk(backup_q == 32'h0000_2222, "R5 latest", backup_q, 32'h0000_2222);
    rd_status();

    // R6 forced full refresh, R3 order
    wr(3'd1, 32'h8000_0001);
    chk(status[23:16] == 8'hFF, "R6 force", 32'(status[23:16]), 32'hFF);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] exp_st;
      exp_st = 8'hFF << (k + 1);
      run_copy();
      chk(status[23:16] == exp_st, "R3 order", 32'(status[23:16]), 32'(exp_st));
    end
    rd_idx = 3'd1; #1;
    chk(backup_q == 32'h8000_0001, "R6 backup", backup_q, 32'h8000_0001);
    chk(status[15:8] == 8'hFF, "R3 new mask", 32'(status[15:8]), 32'hFF);
    rd_status();
    ticks(3);
    chk(status == 32'h0, "R8 after sweep", status, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule